// File: doc/BRIEF.md
# Hardware Loop Sequencer

This block keeps the state of a single hardware loop so that a processor can repeat a stretch of code without executing a branch at the bottom of every pass. When the core retires a loop-start command, it presents the following to the block:

- the PC of that command;
- an end offset;
- a count source, which is either a small immediate stored as the count minus one, or the low half-word of a general register.

The block then computes the loop's first body address and its end address, and loads the iteration count. From then on it watches every retired instruction. When the sequential next PC reaches the end address, the block sends the fetch back to the body top and counts one pass off. On the last pass it lets execution fall through. If the count is zero, the body is skipped: control goes straight to the end address.

The outputs `next_pc_o` and `redirect_o` are combinational. They are valid in the same cycle as the retirement or start they answer. All loop state is registered and changes on the following clock edge. Commands are plain strobes that the block accepts every cycle, so there is no back-pressure. Two kinds of loop start are supported: plain and interruptible. Both load the state in the same way; the block only records which kind was started.

Top module: `hwloop_ctrl`

## Requirements
- R1: With `start_imm_i`=1 the loaded count is `imm_cnt_i` plus one (an immediate of 255 gives 256).
- R2: With `start_imm_i`=0 the loaded count is `reg_cnt_i[15:0]`; the upper register bits have no effect.
- R3: A start whose count is zero drives `redirect_o`=1 and `next_pc_o` = start PC + end offset in that cycle, and leaves the active flag, count, top, end and kind unchanged.
- R4: A start with a non-zero count sets `next_pc_o` = start PC + 1 with `redirect_o`=0. After the edge: `active_o`=1, `loop_top_o` = start PC + 1, `loop_end_o` = start PC + end offset, `count_o` = the loaded count, and `intr_o` = `start_intr_i`.
- R5: A retirement while active, with `seq_pc_i` equal to the loop end and a count above 1, drives `redirect_o`=1 and `next_pc_o` = loop top. The count drops by one at the edge.
- R6: A retirement at the loop end with a count of 1 drives `redirect_o`=0 and `next_pc_o` = `seq_pc_i`. After the edge, `active_o`=0 and `count_o`=0.
- R7: A retirement away from the loop end, or with no loop active, and any cycle with neither start nor retirement, give `redirect_o`=0 and `next_pc_o` = `seq_pc_i`, and leave the state unchanged.
- R8: A non-zero start while a loop is active replaces all loop state.
- R9: If a start and a retirement come in the same cycle, the start wins and the retirement is ignored.
- R10: A synchronous reset (`rst_i`=1, active high) clears the active flag, count, top, end and kind, and takes priority over all commands.
- R11: Address sums wrap modulo 2^16 (start PC 0xFFFF with offset 3 gives top 0x0000 and end 0x0002).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Loop-start command retires this cycle |
| start_imm_i | input | 1 | 1: count from immediate, 0: count from register |
| start_intr_i | input | 1 | 1: interruptible loop kind |
| imm_cnt_i | input | 8 | Immediate count, encoded minus one |
| reg_cnt_i | input | 32 | Register count source; low 16 bits used |
| end_off_i | input | 8 | End offset from the start PC |
| start_pc_i | input | 16 | PC of the loop-start command |
| retire_i | input | 1 | A normal instruction retires this cycle |
| seq_pc_i | input | 16 | Sequential next PC of the retiring instruction |
| next_pc_o | output | 16 | PC the fetch should use next |
| redirect_o | output | 1 | next_pc_o departs from sequential flow |
| active_o | output | 1 | A loop is in progress |
| count_o | output | 16 | Passes remaining |
| loop_top_o | output | 16 | Recorded body top address |
| loop_end_o | output | 16 | Recorded loop end address |
| intr_o | output | 1 | Recorded loop kind |

## Verification
The bench uses the default widths: 16-bit PC, 16-bit count, 8-bit immediate and offset, 32-bit register source. With a 16-bit PC, the address wrap at 0xFFFF can be reached with one start command. With a 16-bit counter, both extremes are in reach: the largest register count of 65535, and the largest immediate count of 256, which needs the ninth bit. The small 8-bit offset keeps the table's loop bodies only a few addresses long, so every path can be driven in one or two cycles each: pass, exit, skip, overwrite and start/retire collision.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  typedef enum logic {
    CNT_FROM_REG = 1'b0,
    CNT_FROM_IMM = 1'b1
  } cnt_src_e;
endpackage

// File: rtl/hwloop_count_sel.sv
module hwloop_count_sel #(
  parameter int IMM_W = 8,
  parameter int REG_W = 32,
  parameter int CNT_W = 16
) (
  input  logic             src_imm_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [REG_W-1:0] reg_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  import hwloop_pkg::*;

  logic [CNT_W-1:0] from_imm;
  logic [CNT_W-1:0] from_reg;

  // Immediate carries count minus one; widen before adding so 255 -> 256.
  assign from_imm = CNT_W'(imm_i) + CNT_W'(1);

  generate
    if (REG_W > CNT_W) begin : g_trim
      logic unused_reg_hi;
      assign from_reg      = reg_i[CNT_W-1:0];
      assign unused_reg_hi = ^reg_i[REG_W-1:CNT_W];
    end else begin : g_widen
      assign from_reg = CNT_W'(reg_i);
    end
  endgenerate

  assign cnt_o  = (cnt_src_e'(src_imm_i) == CNT_FROM_IMM) ? from_imm : from_reg;
  assign zero_o = (cnt_o == '0);
endmodule

// File: rtl/hwloop_steer.sv
module hwloop_steer #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic             zero_i,
  input  logic [PC_W-1:0]  start_pc_i,
  input  logic [OFF_W-1:0] end_off_i,
  input  logic             retire_i,
  input  logic [PC_W-1:0]  seq_pc_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [PC_W-1:0]  top_i,
  input  logic [PC_W-1:0]  end_i,
  output logic [PC_W-1:0]  new_top_o,
  output logic [PC_W-1:0]  new_end_o,
  output logic             hit_o,
  output logic             last_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             redirect_o
);
  assign new_top_o = start_pc_i + PC_W'(1);
  assign new_end_o = start_pc_i + PC_W'(end_off_i);

  // A start outranks a retirement in the same cycle.
  assign hit_o  = retire_i && !start_i && active_i && (seq_pc_i == end_i);
  assign last_o = (cnt_i == CNT_W'(1));

  always_comb begin
    next_pc_o  = seq_pc_i;
    redirect_o = 1'b0;
    if (start_i) begin
      if (zero_i) begin
        next_pc_o  = new_end_o;
        redirect_o = 1'b1;
      end else begin
        next_pc_o = new_top_o;
      end
    end else if (hit_o && !last_o) begin
      next_pc_o  = top_i;
      redirect_o = 1'b1;
    end
  end

  assert_quiet_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!start_i && !retire_i) |-> (!redirect_o && next_pc_o == seq_pc_i));

  assert_back_to_top_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (redirect_o && !start_i) |-> (active_i && next_pc_o == top_i));
endmodule

// File: rtl/hwloop_state.sv
module hwloop_state #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [PC_W-1:0]  top_d_i,
  input  logic [PC_W-1:0]  end_d_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  input  logic             intr_d_i,
  input  logic             hit_i,
  input  logic             last_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [PC_W-1:0]  top_o,
  output logic [PC_W-1:0]  end_o,
  output logic             intr_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      active_o <= 1'b0;
      cnt_o    <= '0;
      top_o    <= '0;
      end_o    <= '0;
      intr_o   <= 1'b0;
    end else if (load_i) begin
      active_o <= 1'b1;
      cnt_o    <= cnt_d_i;
      top_o    <= top_d_i;
      end_o    <= end_d_i;
      intr_o   <= intr_d_i;
    end else if (hit_i) begin
      cnt_o <= cnt_o - CNT_W'(1);
      if (last_i) active_o <= 1'b0;
    end
  end

  assert_reset_clears_R10: assert property (@(posedge clk_i)
    rst_i |=> (!active_o && cnt_o == '0));

  assert_live_count_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    active_o |-> (cnt_o != '0));

  assert_load_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> (active_o && cnt_o == $past(cnt_d_i) && top_o == $past(top_d_i)));

  assert_pass_decrement_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (hit_i && !load_i) |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));

  assert_exit_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (hit_i && !load_i && cnt_o == CNT_W'(1)) |=> !active_o);
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8,
  parameter int IMM_W = 8,
  parameter int REG_W = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic             start_imm_i,
  input  logic             start_intr_i,
  input  logic [IMM_W-1:0] imm_cnt_i,
  input  logic [REG_W-1:0] reg_cnt_i,
  input  logic [OFF_W-1:0] end_off_i,
  input  logic [PC_W-1:0]  start_pc_i,
  input  logic             retire_i,
  input  logic [PC_W-1:0]  seq_pc_i,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             redirect_o,
  output logic             active_o,
  output logic [CNT_W-1:0] count_o,
  output logic [PC_W-1:0]  loop_top_o,
  output logic [PC_W-1:0]  loop_end_o,
  output logic             intr_o
);
  logic [CNT_W-1:0] cnt_new;
  logic             cnt_zero;
  logic [PC_W-1:0]  top_new;
  logic [PC_W-1:0]  end_new;
  logic             hit;
  logic             last;
  logic             load;

  assign load = start_i && !cnt_zero;

  hwloop_count_sel #(.IMM_W(IMM_W), .REG_W(REG_W), .CNT_W(CNT_W)) u_cnt (
    .src_imm_i (start_imm_i),
    .imm_i     (imm_cnt_i),
    .reg_i     (reg_cnt_i),
    .cnt_o     (cnt_new),
    .zero_o    (cnt_zero)
  );

  hwloop_steer #(.PC_W(PC_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_steer (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .start_i    (start_i),
    .zero_i     (cnt_zero),
    .start_pc_i (start_pc_i),
    .end_off_i  (end_off_i),
    .retire_i   (retire_i),
    .seq_pc_i   (seq_pc_i),
    .active_i   (active_o),
    .cnt_i      (count_o),
    .top_i      (loop_top_o),
    .end_i      (loop_end_o),
    .new_top_o  (top_new),
    .new_end_o  (end_new),
    .hit_o      (hit),
    .last_o     (last),
    .next_pc_o  (next_pc_o),
    .redirect_o (redirect_o)
  );

  hwloop_state #(.PC_W(PC_W), .CNT_W(CNT_W)) u_state (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .load_i   (load),
    .top_d_i  (top_new),
    .end_d_i  (end_new),
    .cnt_d_i  (cnt_new),
    .intr_d_i (start_intr_i),
    .hit_i    (hit),
    .last_i   (last),
    .active_o (active_o),
    .cnt_o    (count_o),
    .top_o    (loop_top_o),
    .end_o    (loop_end_o),
    .intr_o   (intr_o)
  );

  assert_skip_keeps_state_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && cnt_zero) |=> ($stable(active_o) && $stable(count_o) && $stable(loop_end_o)));

  assert_start_wins_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !cnt_zero && retire_i) |=> (count_o == $past(cnt_new)));
endmodule

// File: tb/hwloop_ctrl_tb_top.sv
module hwloop_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, simm = 1'b0, sintr = 1'b0, ret = 1'b0;
  logic [7:0]  immv = '0, off = '0;
  logic [31:0] regv = '0;
  logic [15:0] spc = '0, npc = '0;
  logic [15:0] next_pc, cnt, top, lend;
  logic        redir, act, intr;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  hwloop_ctrl dut_i (
    .clk_i(clk), .rst_i(rst), .start_i(start), .start_imm_i(simm),
    .start_intr_i(sintr), .imm_cnt_i(immv), .reg_cnt_i(regv), .end_off_i(off),
    .start_pc_i(spc), .retire_i(ret), .seq_pc_i(npc), .next_pc_o(next_pc),
    .redirect_o(redir), .active_o(act), .count_o(cnt), .loop_top_o(top),
    .loop_end_o(lend), .intr_o(intr)
  );

  typedef struct packed {
    logic        st; logic im; logic ki; logic [7:0] iv; logic [31:0] rv;
    logic [7:0]  of; logic [15:0] sp; logic rt; logic [15:0] np;
    logic        e_red; logic [15:0] e_nxt; logic e_act; logic [15:0] e_cnt;
    logic [15:0] e_top; logic [15:0] e_end; logic e_ki;
  } vec_t;

  // Expected state columns are the registered values before this cycle's edge.
  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,8'd0,32'h0,8'd0,16'h0,1'b1,16'h0010, 1'b0,16'h0010,1'b0,16'd0,16'h0,16'h0,1'b0},
    '{1'b1,1'b1,1'b0,8'd2,32'h0,8'd4,16'h0020,1'b0,16'h0, 1'b0,16'h0021,1'b0,16'd0,16'h0,16'h0,1'b0},
    '{1'b0,1'b0,1'b0,8'd0,32'h0,8'd0,16'h0,1'b1,16'h0022, 1'b0,16'h0022,1'b1,16'd3,16'h21,16'h24,1'b0},
    '{1'b0,1'b0,1'b0,8'd0,32'h0,8'd0,16'h0,1'b1,16'h0024, 1'b1,16'h0021,1'b1,16'd3,16'h21,16'h24,1'b0},
    '{1'b0,1'b0,1'b0,8'd0,32'h0,8'd0,16'h0,1'b1,16'h0024, 1'b1,16'h0021,1'b1,16'd2,16'h21,16'h24,1'b0},
    '{1'b0,1'b0,1'b0,8'd0,32'h0,8'd0,16'h0,1'b1,16'h0024, 1'b0,16'h0024,1'b1,16'd1,16'h21,16'h24,1'b0},
    '{1'b0,1'b0,1'b0,8'd0,32'h0,8'd0,16'h0,1'b1,16'h0025, 1'b0,16'h0025,1'b0,16'd0,16'h21,16'h24,1'b0},
    '{1'b1,1'b0,1'b0,8'd0,32'hABCD0002,8'd2,16'h0030,1'b0,16'h0, 1'b0,16'h0031,1'b0,16'd0,16'h21,16'h24,1'b0},
    '{1'b1,1'b0,1'b1,8'd0,32'h12340000,8'd5,16'h0040,1'b0,16'h0, 1'b1,16'h0045,1'b1,16'd2,16'h31,16'h32,1'b0},
    '{1'b0,1'b0,1'b0,8'd0,32'h0,8'd0,16'h0,1'b1,16'h0032, 1'b1,16'h0031,1'b1,16'd2,16'h31,16'h32,1'b0},
    '{1'b1,1'b1,1'b1,8'd0,32'h0,8'd3,16'h0050,1'b1,16'h0032, 1'b0,16'h0051,1'b1,16'd1,16'h31,16'h32,1'b0},
    '{1'b0,1'b0,1'b0,8'd0,32'h0,8'd0,16'h0,1'b1,16'h0032, 1'b0,16'h0032,1'b1,16'd1,16'h51,16'h53,1'b1},
    '{1'b0,1'b0,1'b0,8'd0,32'h0,8'd0,16'h0,1'b1,16'h0053, 1'b0,16'h0053,1'b1,16'd1,16'h51,16'h53,1'b1},
    '{1'b0,1'b0,1'b0,8'd0,32'h0,8'd0,16'h0,1'b0,16'h0000, 1'b0,16'h0000,1'b0,16'd0,16'h51,16'h53,1'b1}
  };
  // Rows: 0 R7 idle retire; 1 R1/R4 start; 2 R7 off-end; 3-4 R5 passes; 5 R6 exit;
  // 6 R6 after exit; 7 R2 reg start; 8 R3 zero skip; 9 R3 state kept + R5;
  // 10 R8/R9 overwrite with collision; 11 R9 old end ignored; 12 R6; 13 R7 quiet.

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    start = 1'b0; simm = 1'b0; sintr = 1'b0; ret = 1'b0;
    immv = '0; regv = '0; off = '0; spc = '0; npc = '0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    idle();
    repeat (2) @(negedge clk);
    check("R10", "reset active", 32'(act), 32'd0);
    check("R10", "reset count", 32'(cnt), 32'd0);
    check("R10", "reset top", 32'(top), 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      start = TBL[i].st; simm = TBL[i].im; sintr = TBL[i].ki; immv = TBL[i].iv;
      regv = TBL[i].rv; off = TBL[i].of; spc = TBL[i].sp; ret = TBL[i].rt;
      npc = TBL[i].np;
      #1;
      check($sformatf("R3/R5/R7 row%0d", i), "redirect", 32'(redir), 32'(TBL[i].e_red));
      check($sformatf("R3/R4/R5/R6 row%0d", i), "next_pc", 32'(next_pc), 32'(TBL[i].e_nxt));
      check($sformatf("R4/R6/R8 row%0d", i), "active", 32'(act), 32'(TBL[i].e_act));
      check($sformatf("R1/R2/R5 row%0d", i), "count", 32'(cnt), 32'(TBL[i].e_cnt));
      check($sformatf("R4/R8 row%0d", i), "top", 32'(top), 32'(TBL[i].e_top));
      check($sformatf("R4/R8 row%0d", i), "end", 32'(lend), 32'(TBL[i].e_end));
      check($sformatf("R4 row%0d", i), "kind", 32'(intr), 32'(TBL[i].e_ki));
    end

    // R1 boundary: immediate 255 loads 256
    @(negedge clk); idle();
    start = 1'b1; simm = 1'b1; immv = 8'd255; spc = 16'h0100; off = 8'd2;
    @(negedge clk); idle();
    check("R1", "count imm255", 32'(cnt), 32'd256);
    check("R4", "active imm255", 32'(act), 32'd1);

    // R10: reset beats a retirement at the loop end
    rst = 1'b1; ret = 1'b1; npc = 16'h0102;
    @(negedge clk); idle();
    check("R10", "active after reset", 32'(act), 32'd0);
    check("R10", "count after reset", 32'(cnt), 32'd0);
    check("R10", "kind after reset", 32'(intr), 32'd0);
    rst = 1'b0;

    // R11 wrap, R2 max register count
    start = 1'b1; regv = 32'h5555FFFF; spc = 16'hFFFF; off = 8'd3;
    #1;
    check("R11", "next_pc wrap", 32'(next_pc), 32'h0000);
    check("R11", "redirect wrap", 32'(redir), 32'd0);
    @(negedge clk); idle();
    check("R2", "count 0xFFFF", 32'(cnt), 32'hFFFF);
    check("R11", "top wrap", 32'(top), 32'h0000);
    check("R11", "end wrap", 32'(lend), 32'h0002);
    ret = 1'b1; npc = 16'h0002;
    #1;
    check("R5", "redirect wrapped", 32'(redir), 32'd1);
    check("R5", "next_pc wrapped", 32'(next_pc), 32'h0000);
    @(negedge clk); idle();
    check("R5", "count decrement", 32'(cnt), 32'hFFFE);

    // R3 zero-count skip with wrapping end address
    start = 1'b1; regv = 32'h00010000; spc = 16'hFFFE; off = 8'd4;
    #1;
    check("R3", "skip redirect", 32'(redir), 32'd1);
    check("R3", "skip target", 32'(next_pc), 32'h0002);
    @(negedge clk); idle();
    check("R3", "count kept", 32'(cnt), 32'hFFFE);
    check("R3", "end kept", 32'(lend), 32'h0002);

    @(negedge clk);
    summary();
  end
endmodule